// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers external interrupt requests for a small 8-bit CPU into one pending-request latch. The sources are a dedicated active-low interrupt pin and four general port pins. Every pin passes through a two-flop synchronizer. The dedicated pin reacts to falling edges. The port pins react to rising edges, and they take part only when the port-source configuration input is high. A second configuration input switches both kinds of source from edge-only triggering to edge-or-held-level triggering.

A latched request is shown to the CPU only when the software enable bit is set and the CPU's global interrupt mask is clear. The latch is cleared in three ways: by reset, by the CPU's vector-fetch pulse, or by software writing the acknowledge bit. A set event that arrives in the same cycle as a clear wins, so no request is lost. This matters while the CPU is inside a service routine.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the pending flag and the enable bit are 0, `irq_req` is 0 and `reg_rdata` reads 0x00.
- R2: A falling edge on `irq_pin_n` sets the pending flag (`reg_rdata` bit 3) within three clock edges. The flag stays set after the pin returns high.
- R3: In edge mode (`cfg_level`=0), a dedicated pin held low sets the flag only once. After an acknowledge the flag stays clear while the pin remains low.
- R4: In level mode (`cfg_level`=1), a dedicated pin held low keeps setting the flag, so an acknowledge or a vector fetch leaves it set. Once the pin is high, an acknowledge clears it.
- R5: When `cfg_port_en`=1, a rising edge on any `port_pins` bit sets the flag, and a falling edge does not. When `cfg_port_en`=0, port pin activity has no effect on the flag.
- R6: In level mode, a port pin held high keeps the flag set across an acknowledge.
- R7: `irq_req` is 1 exactly when the flag is set, the enable bit is 1 and `cpu_imask` is 0. This is combinational in `cpu_imask`.
- R8: A one-cycle `vec_fetch` pulse clears the flag. A later new edge sets it again.
- R9: A register write with bit 2 (acknowledge) set clears the flag and leaves the enable bit unchanged. Bit 2 always reads 0.
- R10: A register write with bit 2 clear loads the enable bit from `reg_wdata` bit 1, and `reg_rdata` bit 1 returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin |
| port_pins | input | 4 | Port pins usable as interrupt sources |
| cfg_port_en | input | 1 | Lets port pins act as sources |
| cfg_level | input | 1 | 1 = edge-or-level, 0 = edge-only |
| cpu_imask | input | 1 | CPU global interrupt mask bit |
| vec_fetch | input | 1 | Interrupt vector fetch pulse; clears the flag |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data: bit 1 enable, bit 2 acknowledge |
| reg_rdata | output | 8 | Read data: bit 3 flag, bit 1 enable, others 0 |
| irq_req | output | 1 | Request presented to the CPU |

## Verification
The hardest case to reach is a clear and a set event landing in the same cycle. At the ports this happens only when a source keeps producing set events, and that needs level mode. The stimulus holds the dedicated pin, or a port pin, at its active level in level mode. It then issues the acknowledge write and the vector-fetch pulse while the synchronized level is present, and checks that the flag survives both. Edge mode gets the matching check: a held pin must not set the flag again after an acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_PORT = 4;
    localparam int EN_BIT   = 1;
    localparam int ACK_BIT  = 2;
    localparam int FLAG_BIT = 3;

    typedef struct packed {
        logic pend;
        logic en;
    } ctl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_trig.sv
module ext_irq_trig #(
    parameter int NUM_PORT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_n_s,
    input  logic [NUM_PORT-1:0] port_s,
    input  logic                cfg_port_en,
    input  logic                cfg_level,
    output logic                ded_evt,
    output logic                port_evt
);
    typedef struct packed {
        logic                ded_n;
        logic [NUM_PORT-1:0] port;
    } prev_t;

    prev_t               prev_d, prev_q;
    logic [NUM_PORT-1:0] pin_evt;

    always_comb begin
        prev_d.ded_n = irq_n_s;
        prev_d.port  = port_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q.ded_n <= 1'b1;
            prev_q.port  <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // dedicated pin: falling edge, or held low in level mode
    assign ded_evt = ~irq_n_s & (prev_q.ded_n | cfg_level);

    // port pins: rising edge, or held high in level mode
    for (genvar g = 0; g < NUM_PORT; g++) begin : g_pin
        assign pin_evt[g] = port_s[g] & (~prev_q.port[g] | cfg_level);
    end

    assign port_evt = cfg_port_en & (|pin_evt);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_evt,
    input  logic              vec_fetch,
    input  logic              cpu_imask,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req
);
    ctl_t ctl_d, ctl_q;
    logic ack_wr;

    assign ack_wr = reg_wr & reg_wdata[ACK_BIT];

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && !reg_wdata[ACK_BIT]) begin
            ctl_d.en = reg_wdata[EN_BIT];
        end
        // a set event outranks both clear sources
        ctl_d.pend = set_evt | (ctl_q.pend & ~(ack_wr | vec_fetch));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[FLAG_BIT] = ctl_q.pend;
        reg_rdata[EN_BIT]   = ctl_q.en;
    end

    assign irq_req = ctl_q.pend & ctl_q.en & ~cpu_imask;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pins,
    input  logic                cfg_port_en,
    input  logic                cfg_level,
    input  logic                cpu_imask,
    input  logic                vec_fetch,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_req
);
    logic                irq_n_s;
    logic [NUM_PORT-1:0] port_s;
    logic                ded_evt;
    logic                port_evt;
    logic                set_evt;

    ext_irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ded (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_pin_n),
        .dout  (irq_n_s)
    );

    for (genvar g = 0; g < NUM_PORT; g++) begin : g_psync
        ext_irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_port (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (port_pins[g]),
            .dout  (port_s[g])
        );
    end

    ext_irq_trig #(.NUM_PORT(NUM_PORT)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_n_s     (irq_n_s),
        .port_s      (port_s),
        .cfg_port_en (cfg_port_en),
        .cfg_level   (cfg_level),
        .ded_evt     (ded_evt),
        .port_evt    (port_evt)
    );

    assign set_evt = ded_evt | port_evt;

    ext_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt),
        .vec_fetch (vec_fetch),
        .cpu_imask (cpu_imask),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_port_en,
    input logic              cpu_imask,
    input logic              vec_fetch,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_req,
    input logic              set_evt,
    input logic              port_evt
);
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> reg_rdata[FLAG_BIT]); // R4

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[FLAG_BIT] && !vec_fetch && !(reg_wr && reg_wdata[ACK_BIT])) |=> reg_rdata[FLAG_BIT]); // R2

    AST_FETCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && !set_evt) |=> !reg_rdata[FLAG_BIT]); // R8

    AST_ACK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[ACK_BIT]) |=> $stable(reg_rdata[EN_BIT])); // R9

    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[ACK_BIT]); // R9

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_imask |-> !irq_req); // R7

    AST_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_port_en |-> !port_evt); // R5
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_port_en (cfg_port_en),
    .cpu_imask   (cpu_imask),
    .vec_fetch   (vec_fetch),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_req     (irq_req),
    .set_evt     (set_evt),
    .port_evt    (port_evt)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    localparam int CLK_P = 10;
    localparam logic [7:0] W_EN  = 8'h02;
    localparam logic [7:0] W_ACK = 8'h04;
    localparam logic [7:0] M_FLG = 8'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [3:0] port_pins = 4'h0;
    logic       cfg_port_en = 1'b0;
    logic       cfg_level = 1'b0;
    logic       cpu_imask = 1'b0;
    logic       vec_fetch = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_n   (irq_pin_n),
        .port_pins   (port_pins),
        .cfg_port_en (cfg_port_en),
        .cfg_level   (cfg_level),
        .cpu_imask   (cpu_imask),
        .vec_fetch   (vec_fetch),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_req     (irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic fetch();
        vec_fetch = 1'b1;
        cyc(1);
        vec_fetch = 1'b0;
    endtask

    function automatic logic [7:0] flag();
        return reg_rdata & M_FLG;
    endfunction

    task automatic t_reset();
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 irq_req", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_ded_edge();
        wr(W_EN);
        check("R10 enable readback", reg_rdata, W_EN);
        irq_pin_n = 1'b0; cyc(3);
        check("R2 falling edge sets", flag(), M_FLG);
        irq_pin_n = 1'b1; cyc(3);
        check("R2 flag held", flag(), M_FLG);
        check("R7 request out", {7'd0, irq_req}, 8'h01);
        cpu_imask = 1'b1; #1;
        check("R7 masked", {7'd0, irq_req}, 8'h00);
        cpu_imask = 1'b0; #1;
        check("R7 unmasked", {7'd0, irq_req}, 8'h01);
        cyc(1);
        fetch();
        check("R8 fetch clears", flag(), 8'h00);
        irq_pin_n = 1'b0; cyc(3);
        check("R8 new edge sets", flag(), M_FLG);
        irq_pin_n = 1'b1; cyc(3);
        wr(W_ACK);
        check("R9 ack clears", flag(), 8'h00);
    endtask

    task automatic t_edge_hold();
        irq_pin_n = 1'b0; cyc(3);
        check("R3 edge sets", flag(), M_FLG);
        wr(W_ACK);
        cyc(5);
        check("R3 held low no retrigger", flag(), 8'h00);
        check("R9 enable kept, ack reads 0", reg_rdata, W_EN);
        irq_pin_n = 1'b1; cyc(3);
    endtask

    task automatic t_level();
        cfg_level = 1'b1;
        irq_pin_n = 1'b0; cyc(3);
        check("R4 level sets", flag(), M_FLG);
        wr(W_ACK);
        check("R4 ack loses to level", flag(), M_FLG);
        fetch();
        check("R4 fetch loses to level", flag(), M_FLG);
        irq_pin_n = 1'b1; cyc(3);
        wr(W_ACK);
        check("R4 cleared after release", flag(), 8'h00);
        cfg_level = 1'b0;
    endtask

    task automatic t_port();
        cfg_port_en = 1'b0;
        port_pins = 4'b0100; cyc(4);
        check("R5 disabled ignored", flag(), 8'h00);
        port_pins = 4'b0000; cyc(3);
        cfg_port_en = 1'b1;
        port_pins = 4'b1000; cyc(3);
        check("R5 rising edge sets", flag(), M_FLG);
        wr(W_ACK); cyc(4);
        check("R5 held high edge mode", flag(), 8'h00);
        port_pins = 4'b0000; cyc(4);
        check("R5 falling edge ignored", flag(), 8'h00);
    endtask

    task automatic t_port_level();
        cfg_level = 1'b1;
        port_pins = 4'b0001; cyc(3);
        check("R6 port level sets", flag(), M_FLG);
        wr(W_ACK);
        check("R6 port level holds", flag(), M_FLG);
        port_pins = 4'b0000; cyc(3);
        wr(W_ACK);
        check("R6 cleared after release", flag(), 8'h00);
        cfg_level = 1'b0;
        cfg_port_en = 1'b0;
    endtask

    task automatic t_enable();
        wr(8'h00);
        check("R10 enable cleared", reg_rdata, 8'h00);
        irq_pin_n = 1'b0; cyc(3);
        irq_pin_n = 1'b1;
        check("R7 disabled no request", {7'd0, irq_req}, 8'h00);
        wr(W_EN);
        check("R10 enable set", reg_rdata, M_FLG | W_EN);
        check("R7 enabled request", {7'd0, irq_req}, 8'h01);
    endtask

    initial begin
        cyc(2);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_ded_edge();
        t_edge_hold();
        t_level();
        t_port();
        t_port_level();
        t_enable();
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule